// File: doc/BRIEF.md
# Program/Erase Cycle Sequencer

This block runs the internal nonvolatile write and erase cycle of a serial memory. It starts once the host command has been accepted and chip select has returned high. The command decoder gives it a one-cycle `start` pulse, an operation code and a target address. Page data is loaded beforehand into a page-wide staging buffer. The sequencer then holds `wip` high for a fixed number of clock cycles, and that number depends on the operation. Within that window it updates a behavioural byte array: it either copies the staged bytes or writes the erased value 0xFF over a page, a sector or the whole array. When the window ends, the write-enable latch `wel` is cleared.

The busy times are given in milliseconds (6 ms for a program or a page clear, 10 ms for a sector or full clear). They become cycle counts through `CLK_PER_MS`, so a simulation can use a small value. The geometry is set by parameters, which must be powers of two: `PAGE_BYTES` bytes per page, `SECTOR_PAGES` pages per sector and `SECTOR_COUNT` sectors. The defaults are scaled down. The full-size setting is 256-byte pages, 32 KB sectors and four sectors. The long busy window must cover at least one cycle per array byte.

Top module: `nvm_cycle_seq`

## Requirements
- R1: After reset, `wip` and `wel` are both 0.
- R2: A `welSet` pulse while idle makes `wel` 1 from the next cycle. A `welSet` pulse while `wip` is 1 has no effect.
- R3: A `start` pulse is accepted only when `wel` is 1 and `wip` is 0. In any other case it leaves `wip` at 0 and leaves the array unchanged.
- R4: For `opType` 0 (program) and 1 (page clear), `wip` is 1 for exactly `PROG_MS*CLK_PER_MS` cycles, starting the cycle after `start` is accepted.
- R5: For `opType` 2 (sector clear) and 3 (full clear), `wip` is 1 for exactly `BULK_MS*CLK_PER_MS` cycles.
- R6: `wel` returns to 0 on the same edge at which `wip` falls.
- R7: A program operation writes staged byte i (i from 0 to `byteCnt`-1, with values above `PAGE_BYTES` clamped) to the address formed by the page of `targetAddr` and column (`targetAddr` mod `PAGE_BYTES` + i) mod `PAGE_BYTES`. No prior erase is needed, and every other byte keeps its value.
- R8: Page clear sets every byte of the page holding `targetAddr` to 0xFF and changes no other byte.
- R9: Sector clear sets every byte of the `PAGE_BYTES*SECTOR_PAGES`-byte sector holding `targetAddr` to 0xFF and changes no other byte.
- R10: Full clear sets every byte of the array to 0xFF.
- R11: A `start` pulse while `wip` is 1 is ignored. The running cycle keeps its length, and the new operation is not carried out.
- R12: A `bufWe` write while `wip` is 1 leaves the staging buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| welSet | input | 1 | Pulse that sets the write-enable latch |
| start | input | 1 | Pulse that launches the operation once the command is complete |
| opType | input | 2 | 0 program, 1 page clear, 2 sector clear, 3 full clear |
| targetAddr | input | ADDR_W | Byte address: page, sector and start column |
| byteCnt | input | COL_W+1 | Number of staged bytes to program (1 to PAGE_BYTES) |
| bufWe | input | 1 | Staging buffer write strobe |
| bufIdx | input | COL_W | Staging buffer index |
| bufData | input | 8 | Staging buffer write data |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Array byte at `rdAddr` (combinational) |
| wip | output | 1 | Write in progress (bit 0 of the status byte) |
| wel | output | 1 | Write-enable latch |

## Verification
The bound checker checks, on every cycle, the handshake between the latch and the busy flag. `wip` can only rise after an accepted `start` with `wel` set, and a blocked start keeps it low. `wel` cannot change during a busy window and is low when the window closes. A counter in the checker compares each window's length with the length expected for its operation code. What ends up in the array can only be shown by the bench scenarios: column wrap inside a page, overwrite without erase, the extent of each clear, and the fact that a start or buffer write during busy leaves no trace. In these scenarios the whole array is compared with a model after each cycle.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG     = 2'd0,
    OP_PAGE_CLR = 2'd1,
    OP_SECT_CLR = 2'd2,
    OP_FULL_CLR = 2'd3
  } nvmOp_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic launch;   // operation accepted this cycle: latch its extent
    logic finish;   // last busy cycle
  } seqStrobe_t;

endpackage

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int SHORT_CYC = 192,
  parameter int LONG_CYC  = 320,
  parameter int TMR_W     = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       welSet,
  input  logic       start,
  input  logic [1:0] opType,
  output logic       busy,
  output logic       latch,
  output seqStrobe_t strobe
);

  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] durLoad;
  logic             accept;
  nvmOp_e           op;

  assign op     = nvmOp_e'(opType);
  assign accept = start && latch && !busy;

  always_comb begin
    case (op)
      OP_PROG, OP_PAGE_CLR: durLoad = TMR_W'(SHORT_CYC - 1);
      default:              durLoad = TMR_W'(LONG_CYC - 1);
    endcase
  end

  always_comb begin
    strobe.launch = accept;
    strobe.finish = busy && (timer == '0);
  end

  // Busy window timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      timer <= durLoad;
    end else if (strobe.finish) begin
      busy  <= 1'b0;
    end else if (busy) begin
      timer <= timer - 1'b1;
    end
  end

  // Write-enable latch: set only while idle, dropped when the cycle ends
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= 1'b0;
    end else if (strobe.finish) begin
      latch <= 1'b0;
    end else if (welSet && !busy) begin
      latch <= 1'b1;
    end
  end

endmodule

// File: rtl/nvm_seq_datapath.sv
module nvm_seq_datapath
  import nvm_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int SECT_BYTES = 64,
  parameter int MEM_BYTES  = 256,
  parameter int ADDR_W     = 8,
  parameter int COL_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic              busy,
  input  logic [1:0]        opType,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [COL_W:0]    byteCnt,
  input  logic              bufWe,
  input  logic [COL_W-1:0]  bufIdx,
  input  logic [7:0]        bufData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  localparam int LEN_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(SECT_BYTES - 1);
  localparam logic [ADDR_W-1:0] FULL_MASK = ADDR_W'(MEM_BYTES - 1);

  logic [7:0] pageBuf [PAGE_BYTES];
  logic [7:0] cells   [MEM_BYTES];

  // Extent selection at launch
  logic [ADDR_W-1:0] maskSel, offSel;
  logic [LEN_W-1:0]  lenSel;
  logic              fillSel;

  always_comb begin
    case (nvmOp_e'(opType))
      OP_PROG: begin
        maskSel = PAGE_MASK;
        offSel  = targetAddr & PAGE_MASK;
        lenSel  = (byteCnt > (COL_W+1)'(PAGE_BYTES)) ? LEN_W'(PAGE_BYTES)
                                                     : LEN_W'(byteCnt);
        fillSel = 1'b0;
      end
      OP_PAGE_CLR: begin
        maskSel = PAGE_MASK;
        offSel  = '0;
        lenSel  = LEN_W'(PAGE_BYTES);
        fillSel = 1'b1;
      end
      OP_SECT_CLR: begin
        maskSel = SECT_MASK;
        offSel  = '0;
        lenSel  = LEN_W'(SECT_BYTES);
        fillSel = 1'b1;
      end
      default: begin
        maskSel = FULL_MASK;
        offSel  = '0;
        lenSel  = LEN_W'(MEM_BYTES);
        fillSel = 1'b1;
      end
    endcase
  end

  // Walker state
  logic [ADDR_W-1:0] baseQ, maskQ, offQ;
  logic [LEN_W-1:0]  lenQ, ptrQ;
  logic              fillQ;
  logic              walking;
  logic [ADDR_W-1:0] wrAddr;
  logic [7:0]        wrData;

  assign walking = ptrQ < lenQ;
  assign wrAddr  = baseQ | ((offQ + ptrQ[ADDR_W-1:0]) & maskQ);
  assign wrData  = fillQ ? 8'hFF : pageBuf[ptrQ[COL_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ <= '0;
      maskQ <= '0;
      offQ  <= '0;
      lenQ  <= '0;
      ptrQ  <= '0;
      fillQ <= 1'b0;
    end else if (strobe.launch) begin
      baseQ <= targetAddr & ~maskSel;
      maskQ <= maskSel;
      offQ  <= offSel;
      lenQ  <= lenSel;
      ptrQ  <= '0;
      fillQ <= fillSel;
    end else if (walking) begin
      ptrQ  <= ptrQ + 1'b1;
    end
  end

  // Array commit, one byte per cycle inside the busy window
  always_ff @(posedge clk) begin
    if (!strobe.launch && walking) begin
      cells[wrAddr] <= wrData;
    end
  end

  // Staging buffer, frozen while busy
  always_ff @(posedge clk) begin
    if (bufWe && !busy) begin
      pageBuf[bufIdx] <= bufData;
    end
  end

  assign rdData = cells[rdAddr];

endmodule

// File: rtl/nvm_cycle_seq.sv
module nvm_cycle_seq
  import nvm_seq_pkg::*;
#(
  parameter int CLK_PER_MS   = 32,
  parameter int PROG_MS      = 6,
  parameter int BULK_MS      = 10,
  parameter int PAGE_BYTES   = 16,
  parameter int SECTOR_PAGES = 4,
  parameter int SECTOR_COUNT = 4,
  localparam int SECT_BYTES  = PAGE_BYTES * SECTOR_PAGES,
  localparam int MEM_BYTES   = SECT_BYTES * SECTOR_COUNT,
  localparam int ADDR_W      = $clog2(MEM_BYTES),
  localparam int COL_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              welSet,
  input  logic              start,
  input  logic [1:0]        opType,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [COL_W:0]    byteCnt,
  input  logic              bufWe,
  input  logic [COL_W-1:0]  bufIdx,
  input  logic [7:0]        bufData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              wip,
  output logic              wel
);

  localparam int SHORT_CYC = PROG_MS * CLK_PER_MS;
  localparam int LONG_CYC  = BULK_MS * CLK_PER_MS;
  localparam int TMR_W     = $clog2(LONG_CYC + 1);

  seqStrobe_t strobe;

  nvm_seq_ctrl #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .TMR_W     (TMR_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .welSet (welSet),
    .start  (start),
    .opType (opType),
    .busy   (wip),
    .latch  (wel),
    .strobe (strobe)
  );

  nvm_seq_datapath #(
    .PAGE_BYTES (PAGE_BYTES),
    .SECT_BYTES (SECT_BYTES),
    .MEM_BYTES  (MEM_BYTES),
    .ADDR_W     (ADDR_W),
    .COL_W      (COL_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .busy       (wip),
    .opType     (opType),
    .targetAddr (targetAddr),
    .byteCnt    (byteCnt),
    .bufWe      (bufWe),
    .bufIdx     (bufIdx),
    .bufData    (bufData),
    .rdAddr     (rdAddr),
    .rdData     (rdData)
  );

endmodule

// File: rtl/nvm_cycle_seq_chk.sv
module nvm_cycle_seq_chk #(
  parameter int SHORT_CYC = 192,
  parameter int LONG_CYC  = 320,
  parameter int TMR_W     = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] opType,
  input logic       wel,
  input logic       wip
);

  logic [TMR_W-1:0] busyCnt;
  logic [TMR_W-1:0] expDur;

  // Independent window counter: codes 2 and 3 are the long operations
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyCnt <= '0;
      expDur  <= '0;
    end else if (start && wel && !wip) begin
      busyCnt <= '0;
      expDur  <= opType[1] ? TMR_W'(LONG_CYC) : TMR_W'(SHORT_CYC);
    end else if (wip) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  a_r3_rise_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(start) && $past(wel)));

  a_r3_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wel && !wip) |=> !wip);

  a_r6_latch_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  a_r2_latch_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> $stable(wel));

  // R4 and R5: window length per operation, R11: a busy start does not restart it
  a_r4_window_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (busyCnt == expDur));

endmodule

bind nvm_cycle_seq nvm_cycle_seq_chk #(
  .SHORT_CYC (SHORT_CYC),
  .LONG_CYC  (LONG_CYC),
  .TMR_W     (TMR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .opType (opType),
  .wel    (wel),
  .wip    (wip)
);

// File: tb/nvm_cycle_seq_bench.sv
`timescale 1ns/1ps
module nvm_cycle_seq_bench;

  localparam int PAGE  = 16;
  localparam int SECT  = 64;
  localparam int MEM   = 256;
  localparam int SHORT = 6 * 32;
  localparam int LONG  = 10 * 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       welSet = 1'b0;
  logic       start = 1'b0;
  logic [1:0] opType = 2'd0;
  logic [7:0] targetAddr = '0;
  logic [4:0] byteCnt = '0;
  logic       bufWe = 1'b0;
  logic [3:0] bufIdx = '0;
  logic [7:0] bufData = '0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       wip, wel;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model   [MEM];
  logic [7:0] stage   [PAGE];

  always #2.5 clk = ~clk;

  nvm_cycle_seq #(
    .CLK_PER_MS   (32),
    .PROG_MS      (6),
    .BULK_MS      (10),
    .PAGE_BYTES   (PAGE),
    .SECTOR_PAGES (4),
    .SECTOR_COUNT (4)
  ) u_nvm_cycle_seq (
    .clk(clk), .rst_n(rst_n), .welSet(welSet), .start(start), .opType(opType),
    .targetAddr(targetAddr), .byteCnt(byteCnt), .bufWe(bufWe), .bufIdx(bufIdx),
    .bufData(bufData), .rdAddr(rdAddr), .rdData(rdData), .wip(wip), .wel(wel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseWel();
    @(negedge clk); welSet = 1'b1;
    @(negedge clk); welSet = 1'b0;
  endtask

  task automatic loadByte(input int idx, input logic [7:0] v);
    @(negedge clk); bufWe = 1'b1; bufIdx = idx[3:0]; bufData = v;
    @(negedge clk); bufWe = 1'b0;
    stage[idx] = v;
  endtask

  task automatic launch(input logic [1:0] op, input int addr, input int cnt);
    @(negedge clk);
    start = 1'b1; opType = op; targetAddr = addr[7:0]; byteCnt = cnt[4:0];
    @(negedge clk);
    start = 1'b0;
  endtask

  // Counts busy cycles; at busy cycle pokeAt applies a one-cycle poke
  // kind 1: start with full clear, kind 2: welSet, kind 3: buffer write idx 0
  task automatic waitBusy(input int pokeAt, input int kind, output int n);
    n = 0;
    while (wip && n < 2000) begin
      n++;
      if (n == pokeAt) begin
        case (kind)
          1: begin start = 1'b1; opType = 2'd3; end
          2: welSet = 1'b1;
          3: begin bufWe = 1'b1; bufIdx = 4'd0; bufData = 8'hC3; end
          default: ;
        endcase
      end
      @(negedge clk);
      start = 1'b0; welSet = 1'b0; bufWe = 1'b0;
    end
  endtask

  task automatic modelProg(input int addr, input int cnt);
    int base = addr & ~(PAGE - 1);
    int col  = addr % PAGE;
    for (int i = 0; i < cnt; i++) model[base + ((col + i) % PAGE)] = stage[i];
  endtask

  task automatic modelFill(input int base, input int len);
    for (int i = 0; i < len; i++) model[base + i] = 8'hFF;
  endtask

  task automatic compareMem(input string req);
    int bad = 0; int badAddr = 0; int act = 0; int exp = 0;
    for (int a = 0; a < MEM; a++) begin
      rdAddr = a[7:0];
      #1;
      if (rdData !== model[a]) begin
        if (bad == 0) begin badAddr = a; act = rdData; exp = model[a]; end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("array byte %0d", badAddr), act, exp);
    @(negedge clk);
  endtask

  task automatic tReset();
    check(wip === 1'b0, "R1", "wip after reset", wip, 0);
    check(wel === 1'b0, "R1", "wel after reset", wel, 0);
  endtask

  task automatic tBlockedStart();
    launch(2'd3, 0, 0);
    repeat (3) @(negedge clk);
    check(wip === 1'b0, "R3", "wip after start with latch clear", wip, 0);
  endtask

  task automatic tSetLatch();
    pulseWel();
    check(wel === 1'b1, "R2", "wel after welSet", wel, 1);
  endtask

  task automatic tFullClear();
    int n;
    launch(2'd3, 8'h5A, 0);
    waitBusy(0, 0, n);
    check(n == LONG, "R5", "full clear busy cycles", n, LONG);
    check(wel === 1'b0, "R6", "wel after cycle", wel, 0);
    modelFill(0, MEM);
    compareMem("R10");
  endtask

  task automatic tProgram();
    int n;
    for (int i = 0; i < 5; i++) loadByte(i, 8'h10 + 8'(i));
    pulseWel();
    launch(2'd0, 46, 5);
    waitBusy(0, 0, n);
    check(n == SHORT, "R4", "program busy cycles", n, SHORT);
    modelProg(46, 5);
    compareMem("R7");
    for (int i = 0; i < PAGE; i++) loadByte(i, 8'h80 + 8'(i));
    pulseWel();
    launch(2'd0, 48, 16);
    waitBusy(0, 0, n);
    modelProg(48, 16);
    compareMem("R7");
    loadByte(0, 8'hA5);
    pulseWel();
    launch(2'd0, 32, 1);
    waitBusy(0, 0, n);
    modelProg(32, 1);
    compareMem("R7");
  endtask

  task automatic tPageClear();
    int n;
    pulseWel();
    launch(2'd1, 37, 0);
    waitBusy(0, 0, n);
    check(n == SHORT, "R4", "page clear busy cycles", n, SHORT);
    modelFill(32, PAGE);
    compareMem("R8");
  endtask

  task automatic tSectorClear();
    int n;
    for (int i = 0; i < PAGE; i++) loadByte(i, 8'h40 ^ 8'(i));
    pulseWel(); launch(2'd0, 64, 16); waitBusy(0, 0, n); modelProg(64, 16);
    pulseWel(); launch(2'd0, 112, 16); waitBusy(0, 0, n); modelProg(112, 16);
    pulseWel(); launch(2'd0, 128, 16); waitBusy(0, 0, n); modelProg(128, 16);
    compareMem("R7");
    pulseWel();
    launch(2'd2, 100, 0);
    waitBusy(0, 0, n);
    check(n == LONG, "R5", "sector clear busy cycles", n, LONG);
    modelFill(64, SECT);
    compareMem("R9");
  endtask

  task automatic tStartWhileBusy();
    int n;
    for (int i = 0; i < 3; i++) loadByte(i, 8'hD0 + 8'(i));
    pulseWel();
    launch(2'd0, 200, 3);
    waitBusy(10, 1, n);
    check(n == SHORT, "R11", "busy cycles with start during busy", n, SHORT);
    repeat (4) @(negedge clk);
    check(wip === 1'b0, "R11", "no second cycle after busy start", wip, 0);
    modelProg(200, 3);
    compareMem("R11");
  endtask

  task automatic tLatchWhileBusy();
    int n;
    pulseWel();
    launch(2'd1, 0, 0);
    waitBusy(20, 2, n);
    check(wel === 1'b0, "R2", "wel after welSet during busy", wel, 0);
    modelFill(0, PAGE);
    compareMem("R8");
  endtask

  task automatic tBufferWhileBusy();
    int n;
    loadByte(0, 8'h3C);
    pulseWel();
    launch(2'd0, 128, 1);
    waitBusy(30, 3, n);
    pulseWel();
    launch(2'd0, 129, 1);
    waitBusy(0, 0, n);
    modelProg(128, 1);
    modelProg(129, 1);
    rdAddr = 8'd129;
    #1;
    check(rdData === 8'h3C, "R12", "byte from buffer after busy write", rdData, 8'h3C);
    compareMem("R12");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tBlockedStart();
    tSetLatch();
    tFullClear();
    tProgram();
    tPageClear();
    tSectorClear();
    tStartWhileBusy();
    tLatchWhileBusy();
    tBufferWhileBusy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule